// File: doc/BRIEF.md
# Command Byte I2C Slave with Status Readback

This block lets a host controller send command bytes to a processing core over a two-wire I2C bus and poll a one-byte status code. SCL and SDA are brought into the system clock domain, filtered for short glitches, and decoded into start, stop and data events. Bytes written to the slave go into a small command queue. The core drains that queue through a valid/ready byte stream.

Every read transaction returns a status byte that the block builds from its own state and from two flags that the core supplies. For a set number of cycles after reset is released, the slave reports itself not ready and refuses command bytes.

The slave address is seven bits: binary `001100` followed by a strap pin. The strap therefore selects 0x18 or 0x19. SDA is only ever pulled low or released. The output `sda_oe` high means the pad pulls SDA low.

Top module: `cmd_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {6'b001100, addr_strap}. It ignores every other address and does not drive SDA for the rest of that transaction.
- R2: After a matched write address, each data byte (MSB first) is acknowledged and queued in arrival order. It appears on `cmd_data` with `cmd_valid` high, and `cmd_data` holds until `cmd_ready` is seen high.
- R3: For INIT_CYCLES clock cycles after reset is released, the slave NACKs written data bytes and drops them, and every read returns 0x83.
- R4: Once ready, a read returns 0x80 when no error is pending, the queue is empty and `core_busy` is low.
- R5: A read returns 0x82 while bytes wait in the queue or `core_busy` is high, provided no error is pending.
- R6: The queue holds CMDQ_DEPTH+1 bytes. A further byte is still acknowledged but dropped, and the status becomes 0x81. That error stays until the next write address phase that matches this slave.
- R7: While `core_err` is high, a ready slave reports 0x81, which takes priority over 0x82.
- R8: A read sends the status MSB first. A master ACK makes the slave send the status again, and a master NACK ends the transfer.
- R9: A repeated start restarts address matching, and bytes already queued stay queued and are later delivered in order.
- R10: A pulse on SCL shorter than FILT_LEN system clocks is ignored.
- R11: SDA is released in idle and is pulled low only starting while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as sensed at the pad |
| sda_i | input | 1 | I2C data line as sensed at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_strap | input | 1 | Least significant slave address bit |
| cmd_data | output | 8 | Command byte at the queue head |
| cmd_valid | output | 1 | `cmd_data` holds a byte |
| cmd_ready | input | 1 | Core takes the byte this cycle |
| core_busy | input | 1 | Core is still executing a command |
| core_err | input | 1 | Core rejected a command |

## Verification
The bench builds the slave with a four-entry queue, so a stalled core reaches overflow after five bytes. It sets INIT_CYCLES to 5000, so that both the not-ready window and the ready state can be reached within one short run. It uses a three-sample glitch filter, and a two-cycle SCL spike in mid-byte then checks R10.

// File: rtl/cmdi2c_pkg.sv
package cmdi2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_SKIP
  } i2c_st_e;

  localparam logic [7:0] STS_OK   = 8'h80;
  localparam logic [7:0] STS_ERR  = 8'h81;
  localparam logic [7:0] STS_BUSY = 8'h82;
  localparam logic [7:0] STS_NRDY = 8'h83;

  localparam logic [5:0] ADDR_UPPER = 6'b001100;

endpackage

// File: rtl/cmdi2c_filter.sv
module cmdi2c_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  // the output follows only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      filt  <= 1'b1;
      run_q <= '0;
    end else if (synced != filt) begin
      if (run_q == CW'(FILT_LEN - 1)) begin
        filt  <= synced;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end

endmodule

// File: rtl/cmdi2c_cmdq.sv
module cmdi2c_cmdq #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  output logic         pending,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          pop_mem;

  assign pop_mem = (cnt != '0) && (!out_valid || out_ready);
  assign full    = (cnt == CW'(DEPTH));
  assign pending = out_valid || (cnt != '0);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (pop_mem) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_en)   wr_ptr <= wr_ptr + 1'b1;
      if (pop_mem) rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + CW'(wr_en) - CW'(pop_mem);
      if (pop_mem)        out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);

  p_hold_head_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/cmdi2c_status.sv
module cmdi2c_status
  import cmdi2c_pkg::*;
#(
  parameter int INIT_CYCLES = 2500000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       core_busy,
  input  logic       core_err,
  input  logic       q_pending,
  input  logic       ovf_set,
  input  logic       err_clr,
  output logic       ready,
  output logic [7:0] status_code
);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  logic [IW-1:0] init_cnt;
  logic          err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_cnt <= '0;
      ready    <= 1'b0;
    end else if (!ready) begin
      if (init_cnt == IW'(INIT_CYCLES - 1)) ready <= 1'b1;
      init_cnt <= init_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          err_q <= 1'b0;
    else if (ovf_set) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                        status_code <= STS_NRDY;
    else if (!ready)                status_code <= STS_NRDY;
    else if (err_q || core_err)     status_code <= STS_ERR;
    else if (core_busy || q_pending) status_code <= STS_BUSY;
    else                            status_code <= STS_OK;
  end

  p_nrdy_window_r3: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (status_code == STS_NRDY));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> (status_code == STS_ERR));

endmodule

// File: rtl/cmd_i2c_slave.sv
module cmd_i2c_slave
  import cmdi2c_pkg::*;
#(
  parameter int CMDQ_DEPTH  = 16,
  parameter int INIT_CYCLES = 2500000,
  parameter int FILT_LEN    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_strap,
  output logic [7:0] cmd_data,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  input  logic       core_busy,
  input  logic       core_err
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw, line_filt;
  logic scl_f, sda_f, scl_d, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_flt
    cmdi2c_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_flt (
      .clk (clk),
      .rst (rst),
      .raw (line_raw[g]),
      .filt(line_filt[g])
    );
  end

  assign scl_f = line_filt[0];
  assign sda_f = line_filt[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise  = scl_f && !scl_d;
  assign scl_fall  = !scl_f && scl_d;
  assign start_det = scl_f && scl_d && sda_d && !sda_f;
  assign stop_det  = scl_f && scl_d && !sda_d && sda_f;

  i2c_st_e    state;
  logic [7:0] shreg, tx_q;
  logic [3:0] bitcnt;
  logic       rw_q;

  logic       q_full, q_pending, ready;
  logic [7:0] status_code;
  logic       addr_hit, addr_done, wr_done, push, ovf, err_clr;

  assign addr_hit  = (shreg[7:1] == {ADDR_UPPER, addr_strap});
  assign addr_done = (state == ST_ADDR) && scl_fall && (bitcnt == 4'd8);
  assign wr_done   = (state == ST_WDATA) && scl_fall && (bitcnt == 4'd8);
  assign push      = wr_done && ready && !q_full;
  assign ovf       = wr_done && ready && q_full;
  assign err_clr   = addr_done && addr_hit && !shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      shreg  <= '0;
      tx_q   <= '0;
      bitcnt <= '0;
      rw_q   <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise && (bitcnt < 4'd8)) begin
            shreg  <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 1'b1;
          end
          if (addr_done) begin
            if (addr_hit) begin
              sda_oe <= 1'b1;
              rw_q   <= shreg[0];
              tx_q   <= status_code;
              state  <= ST_ADDR_ACK;
            end else begin
              state  <= ST_SKIP;
            end
          end
          if (wr_done) begin
            sda_oe <= ready;
            state  <= ST_WACK;
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              state  <= ST_RDATA;
              sda_oe <= !tx_q[7];
              tx_q   <= {tx_q[6:0], 1'b0};
              bitcnt <= 4'd1;
            end else begin
              state  <= ST_WDATA;
              sda_oe <= 1'b0;
              bitcnt <= '0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WDATA;
            bitcnt <= '0;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end else begin
              sda_oe <= !tx_q[7];
              tx_q   <= {tx_q[6:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            if (sda_f) state <= ST_SKIP;
            else       tx_q  <= status_code;
          end
          if (scl_fall) begin
            state  <= ST_RDATA;
            sda_oe <= !tx_q[7];
            tx_q   <= {tx_q[6:0], 1'b0};
            bitcnt <= 4'd1;
          end
        end
        default: ;
      endcase
    end
  end

  cmdi2c_cmdq #(
    .W    (8),
    .DEPTH(CMDQ_DEPTH)
  ) u_cmdq (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (push),
    .wr_data  (shreg),
    .full     (q_full),
    .pending  (q_pending),
    .out_data (cmd_data),
    .out_valid(cmd_valid),
    .out_ready(cmd_ready)
  );

  cmdi2c_status #(
    .INIT_CYCLES(INIT_CYCLES)
  ) u_status (
    .clk        (clk),
    .rst        (rst),
    .core_busy  (core_busy),
    .core_err   (core_err),
    .q_pending  (q_pending),
    .ovf_set    (ovf),
    .err_clr    (err_clr),
    .ready      (ready),
    .status_code(status_code)
  );

  p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_f);

  p_idle_released_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  p_nack_not_ready_r3: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_WACK) && !ready) |-> !sda_oe);

  p_skip_silent_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP) |-> !sda_oe);

endmodule

// File: tb/cmd_i2c_slave_tb.sv
`timescale 1ns/1ps
module cmd_i2c_slave_tb;
  localparam int DEPTH = 4;
  localparam int CAP   = DEPTH + 1;
  localparam int INIT  = 5000;
  localparam int FILT  = 3;
  localparam int Q     = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic strap = 1'b0, ready_in = 1'b1, busy_in = 1'b0, err_in = 1'b0;
  logic sda_oe, sda_line, cmd_valid;
  logic [7:0] cmd_data;

  assign sda_line = m_sda & ~sda_oe;

  cmd_i2c_slave #(
    .CMDQ_DEPTH (DEPTH),
    .INIT_CYCLES(INIT),
    .FILT_LEN   (FILT),
    .SYNC_STAGES(2)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .addr_strap(strap),
    .cmd_data  (cmd_data),
    .cmd_valid (cmd_valid),
    .cmd_ready (ready_in),
    .core_busy (busy_in),
    .core_err  (err_in)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  bit quiet = 1'b1, done = 1'b0, m_err = 1'b0;
  logic [7:0] mq[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sts(input bit in_init);
    if (in_init)                        return 8'h83;
    else if (m_err || err_in)           return 8'h81;
    else if (busy_in || mq.size() != 0) return 8'h82;
    else                                return 8'h80;
  endfunction

  task automatic model_push(input logic [7:0] b);
    if (mq.size() >= CAP) m_err = 1'b1;
    else mq.push_back(b);
  endtask

  always @(posedge clk) cyc++;

  // reference comparison on every clock, 1 ns before the next rising edge
  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      if (cmd_valid && ready_in) begin
        if (mq.size() == 0) check("R2 unexpected byte", {24'd0, cmd_data}, 32'h100);
        else begin
          check("R2/R9 delivered byte", {24'd0, cmd_data}, {24'd0, mq[0]});
          void'(mq.pop_front());
        end
      end
      if (quiet) check("R11 released when idle", {31'd0, sda_oe}, 32'd0);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; hq();
    m_scl = 1'b1; hq();
    m_sda = 1'b0; hq();
    m_scl = 1'b0; hq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; hq();
    m_scl = 1'b1; hq();
    m_sda = 1'b1; hq();
  endtask

  task automatic wbit(input bit b, input bit glitch);
    m_sda = b;
    if (glitch) begin
      repeat (5) @(negedge clk);
      m_scl = 1'b1;
      repeat (FILT - 1) @(negedge clk);
      m_scl = 1'b0;
      repeat (Q - 5 - (FILT - 1)) @(negedge clk);
    end else hq();
    m_scl = 1'b1; hq(); hq();
    m_scl = 1'b0; hq();
  endtask

  task automatic rbit(output bit b);
    m_sda = 1'b1; hq();
    m_scl = 1'b1; hq();
    b = sda_line; hq();
    m_scl = 1'b0; hq();
  endtask

  task automatic send_byte(input logic [7:0] v, input bit glitch, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) wbit(v[i], glitch && (i == 4));
    rbit(b);
    acked = !b;
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    wbit(nack, 1'b0);
  endtask

  task automatic wr_txn(input logic [6:0] a, input bit exp_aack, input int n,
                        input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                        input bit exp_dack, input bit glitch, input string tag);
    bit ack;
    logic [7:0] d;
    quiet = 1'b0;
    i2c_start();
    send_byte({a, 1'b0}, 1'b0, ack);
    check({tag, " address ack"}, {31'd0, ack}, {31'd0, exp_aack});
    if (exp_aack) m_err = 1'b0;
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
      if (exp_aack && exp_dack) model_push(d);
      send_byte(d, glitch, ack);
      check({tag, " data ack"}, {31'd0, ack}, {31'd0, exp_aack && exp_dack});
    end
    i2c_stop();
    hq();
    quiet = 1'b1;
  endtask

  task automatic rd_txn(input logic [6:0] a, input int n, input bit in_init, input string tag);
    bit ack;
    logic [7:0] v, e;
    quiet = 1'b0;
    i2c_start();
    e = exp_sts(in_init);
    send_byte({a, 1'b1}, 1'b0, ack);
    check({tag, " read address ack"}, {31'd0, ack}, 32'd1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, v);
      check({tag, " status byte"}, {24'd0, v}, {24'd0, e});
    end
    i2c_stop();
    hq();
    quiet = 1'b1;
  endtask

  initial begin
    bit ack;
    logic [7:0] v;
    repeat (4) @(negedge clk);
    check("R11 reset sda_oe", {31'd0, sda_oe}, 32'd0);
    check("R2 reset cmd_valid", {31'd0, cmd_valid}, 32'd0);
    rst = 1'b0;
    hq();

    // R3: not ready window
    rd_txn(7'h18, 1, 1'b1, "R3 R8 not ready");
    wr_txn(7'h18, 1'b1, 1, 8'h11, 8'h00, 8'h00, 1'b0, 1'b0, "R3 init write");
    check("R3 byte dropped", {31'd0, cmd_valid}, 32'd0);
    while (cyc < INIT + 800) @(negedge clk);

    // R4, R8: idle status, repeated via master ACK
    rd_txn(7'h18, 2, 1'b0, "R4 R8 idle");

    // R1: wrong address, then R2 ordered delivery
    wr_txn(7'h19, 1'b0, 1, 8'h77, 8'h00, 8'h00, 1'b0, 1'b0, "R1 strap low other addr");
    wr_txn(7'h18, 1'b1, 2, 8'hA5, 8'h3C, 8'h00, 1'b1, 1'b0, "R2 write");
    repeat (10) @(negedge clk);
    check("R2 queue drained", mq.size(), 32'd0);
    strap = 1'b1;
    wr_txn(7'h18, 1'b0, 1, 8'h55, 8'h00, 8'h00, 1'b0, 1'b0, "R1 strap high old addr");
    wr_txn(7'h19, 1'b1, 1, 8'hC3, 8'h00, 8'h00, 1'b1, 1'b0, "R1 strap high");
    rd_txn(7'h19, 1, 1'b0, "R4 strap high read");
    strap = 1'b0;

    // R5, R7: core flags
    busy_in = 1'b1;
    rd_txn(7'h18, 1, 1'b0, "R5 core busy");
    err_in = 1'b1;
    rd_txn(7'h18, 1, 1'b0, "R7 error over busy");
    busy_in = 1'b0;
    rd_txn(7'h18, 1, 1'b0, "R7 core error");
    err_in = 1'b0;

    // R9: repeated start with stalled core
    ready_in = 1'b0;
    quiet = 1'b0;
    i2c_start();
    send_byte({7'h18, 1'b0}, 1'b0, ack);
    check("R9 write address ack", {31'd0, ack}, 32'd1);
    for (int i = 1; i <= 3; i++) begin
      model_push(8'(i));
      send_byte(8'(i), 1'b0, ack);
      check("R9 data ack", {31'd0, ack}, 32'd1);
    end
    i2c_start();
    send_byte({7'h18, 1'b1}, 1'b0, ack);
    check("R9 read address after repeated start", {31'd0, ack}, 32'd1);
    recv_byte(1'b1, v);
    check("R9 R5 pending status", {24'd0, v}, {24'd0, exp_sts(1'b0)});
    i2c_stop();
    hq();
    quiet = 1'b1;
    check("R2 head held valid", {31'd0, cmd_valid}, 32'd1);
    check("R2 head held data", {24'd0, cmd_data}, 32'h01);

    // R6: overflow
    wr_txn(7'h18, 1'b1, 3, 8'h04, 8'h05, 8'h06, 1'b1, 1'b0, "R6 overflow");
    rd_txn(7'h18, 1, 1'b0, "R6 overflow status");
    ready_in = 1'b1;
    repeat (30) @(negedge clk);
    check("R9 queued bytes drained", mq.size(), 32'd0);
    rd_txn(7'h18, 1, 1'b0, "R6 error sticky");
    wr_txn(7'h18, 1'b1, 0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R6 clear");
    rd_txn(7'h18, 1, 1'b0, "R6 cleared");

    // R10: short SCL spike inside a byte
    wr_txn(7'h18, 1'b1, 1, 8'h9A, 8'h00, 8'h00, 1'b1, 1'b1, "R10 glitch");
    repeat (10) @(negedge clk);
    check("R10 glitched byte delivered", mq.size(), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule